// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the write side of a parallel NOR-flash style bus and interprets the host's write cycles as commands. Each write is framed by the chip-enable and write-enable strobes, both active low, and carries an address and a data word. The block samples these inputs synchronously. A command takes effect only after the exact unlock prefix. Once a program or erase sequence completes, the block emits a single-cycle launch pulse to the embedded algorithm, together with the operation code, the captured address and the captured data.

The block also has an identification read space. Once the identification command has been accepted, a combinational read mux answers at the current bus address. It returns a manufacturer code, a device code whose width follows the byte/word mode input, or the protect flag of the sector selected by the upper address bits. While the embedded engine reports busy, every completed write is discarded. The array, the erase timers and the status polling live elsewhere.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After synchronous reset the mode output is 0 (read array), launch_valid is 0 and id_valid is 0.
- R2: The write sequence AAH at word address 555H, then 55H at 2AAH, then A0H at 555H sets mode 2 (program). The next write then pulses launch_valid for exactly one cycle, in the cycle after that write ends. The pulse carries launch_op 1 together with that write's address and data, and mode returns to 0. Unlock and command addresses compare on address bits [10:0], and command bytes are data bits [7:0].
- R3: The write sequence AAH@555H, 55H@2AAH, 80H@555H sets mode 3 (erase armed), and mode 3 holds through a further AAH@555H and 55H@2AAH. A final write of 10H at any address then launches launch_op 2 (chip erase) and returns to mode 0.
- R4: The same six-write sequence, ending in 30H, launches launch_op 3 (sector erase) with launch_addr equal to the address of that last write. The sector is given by address bits [17:15].
- R5: Any write that does not match the expected unlock or command step returns the mode to 0 and produces no launch. This covers a wrong address, a wrong byte, an unknown command and F0H.
- R6: The write address is taken in the cycle where both strobes are first seen low. The write data is taken in the last cycle where both strobes are low. Address and data changes outside those cycles have no effect.
- R7: The unlock prefix followed by 90H@555H sets mode 1 (identification) and raises id_valid.
- R8: In mode 1, address bits [7:0] = 00H read 0001H. Address bits [7:0] = 01H read 0023H when word_mode is 0 and 2223H when word_mode is 1. In both codes, bit 7 makes data bits [7:0] odd parity.
- R9: In mode 1, an address with bit 6 = 0 and bits [1:0] = 10b reads bit 0 equal to sector_prot[address bits 17:15], with all other bits 0.
- R10: Mode 1 is left only by a write of F0H at any address, which returns to mode 0. Every other write, including unlock and program commands, keeps mode 1 and launches nothing.
- R11: A write that completes while busy is high changes neither the mode nor any sequence progress, and produces no launch.
- R12: Outside mode 1, id_valid is 0 and id_data is 0000H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_addr | input | 18 | Word address |
| bus_wdata | input | 16 | Write data |
| word_mode | input | 1 | 1 selects 16-bit identifier width |
| busy | input | 1 | Embedded operation in progress |
| sector_prot | input | 8 | Protect flag per sector |
| mode | output | 2 | 0 read, 1 identification, 2 program, 3 erase armed |
| launch_valid | output | 1 | One-cycle operation launch |
| launch_op | output | 2 | 1 program, 2 chip erase, 3 sector erase |
| launch_addr | output | 18 | Captured address for the launch |
| launch_data | output | 16 | Captured data for the launch |
| id_valid | output | 1 | Identification read space active |
| id_data | output | 16 | Identification read data |

## Verification
The case hardest to reach from the ports is a write whose address and data move while the strobes are still changing. Before both strobes are low, the address takes one value. It takes a second value when the later strobe falls, and a third while the strobes stay low. The data takes a new value in the same cycle the write strobe rises. The stimulus staggers chip enable and write enable cycle by cycle and changes the buses at each step. Only the address from the falling step and the data from the last low cycle may appear in the launch. Busy is raised exactly across the data write of a program sequence, and again across the exit write of identification mode, to show that sequence progress survives a discarded write.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [1:0] {
        MODE_READ  = 2'd0,
        MODE_IDENT = 2'd1,
        MODE_PROG  = 2'd2,
        MODE_ERASE = 2'd3
    } bus_mode_e;

    typedef enum logic [1:0] {
        OP_NONE         = 2'd0,
        OP_PROGRAM      = 2'd1,
        OP_CHIP_ERASE   = 2'd2,
        OP_SECTOR_ERASE = 2'd3
    } launch_op_e;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_KEY1,
        SEQ_KEY2,
        SEQ_PROG_DATA,
        SEQ_ER_ARMED,
        SEQ_ER_KEY1,
        SEQ_ER_KEY2,
        SEQ_IDENT
    } seq_state_e;

    localparam int KEY_ADDR_W = 11;

    localparam logic [KEY_ADDR_W-1:0] KEY1_ADDR = 11'h555;
    localparam logic [KEY_ADDR_W-1:0] KEY2_ADDR = 11'h2AA;
    localparam logic [7:0] KEY1_BYTE       = 8'hAA;
    localparam logic [7:0] KEY2_BYTE       = 8'h55;
    localparam logic [7:0] CMD_IDENT       = 8'h90;
    localparam logic [7:0] CMD_PROGRAM     = 8'hA0;
    localparam logic [7:0] CMD_ERASE_SETUP = 8'h80;
    localparam logic [7:0] CMD_CHIP        = 8'h10;
    localparam logic [7:0] CMD_SECTOR      = 8'h30;
    localparam logic [7:0] CMD_RESET       = 8'hF0;

    // Extend a 7-bit code with a top bit that makes the byte odd parity.
    function automatic logic [7:0] odd_parity_byte(input logic [6:0] v);
        return {~^v, v};
    endfunction

    function automatic bus_mode_e mode_of(input seq_state_e s);
        case (s)
            SEQ_IDENT:     return MODE_IDENT;
            SEQ_PROG_DATA: return MODE_PROG;
            SEQ_ER_ARMED,
            SEQ_ER_KEY1,
            SEQ_ER_KEY2:   return MODE_ERASE;
            default:       return MODE_READ;
        endcase
    endfunction

endpackage

// File: rtl/bus_write_capture.sv
module bus_write_capture
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              wr_done,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data
);

    logic wr_act;
    logic wr_act_q;

    assign wr_act  = !ce_n && !we_n;
    assign wr_done = wr_act_q && !wr_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_act_q <= 1'b0;
            cap_addr <= '0;
            cap_data <= '0;
        end else begin
            wr_act_q <= wr_act;
            // address: first cycle where the later strobe has fallen
            if (wr_act && !wr_act_q)
                cap_addr <= addr;
            // data: keeps following the bus until a strobe rises
            if (wr_act)
                cap_data <= wdata;
        end
    end

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_act && wr_act_q) |=> (cap_addr == $past(cap_addr)));

endmodule

// File: rtl/cmd_sequencer.sv
module cmd_sequencer
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_done,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic [DATA_W-1:0] cap_data,
    input  logic              busy,
    output bus_mode_e         mode,
    output logic              launch_valid,
    output launch_op_e        launch_op,
    output logic [ADDR_W-1:0] launch_addr,
    output logic [DATA_W-1:0] launch_data
);

    seq_state_e state, state_nxt;
    logic       fire;
    launch_op_e fire_op;
    logic       take;
    logic       is_key1, is_key2, at_cmd_addr;
    logic [KEY_ADDR_W-1:0] lo_addr;
    logic [7:0]            cmd;

    assign lo_addr     = cap_addr[KEY_ADDR_W-1:0];
    assign cmd         = cap_data[7:0];
    assign take        = wr_done && !busy;
    assign is_key1     = (lo_addr == KEY1_ADDR) && (cmd == KEY1_BYTE);
    assign is_key2     = (lo_addr == KEY2_ADDR) && (cmd == KEY2_BYTE);
    assign at_cmd_addr = (lo_addr == KEY1_ADDR);

    always_comb begin
        state_nxt = state;
        fire      = 1'b0;
        fire_op   = OP_NONE;
        if (take) begin
            case (state)
                SEQ_IDLE:  state_nxt = is_key1 ? SEQ_KEY1 : SEQ_IDLE;
                SEQ_KEY1:  state_nxt = is_key2 ? SEQ_KEY2 : SEQ_IDLE;
                SEQ_KEY2: begin
                    state_nxt = SEQ_IDLE;
                    if (at_cmd_addr) begin
                        case (cmd)
                            CMD_IDENT:       state_nxt = SEQ_IDENT;
                            CMD_PROGRAM:     state_nxt = SEQ_PROG_DATA;
                            CMD_ERASE_SETUP: state_nxt = SEQ_ER_ARMED;
                            default:         state_nxt = SEQ_IDLE;
                        endcase
                    end
                end
                SEQ_PROG_DATA: begin
                    state_nxt = SEQ_IDLE;
                    fire      = 1'b1;
                    fire_op   = OP_PROGRAM;
                end
                SEQ_ER_ARMED: state_nxt = is_key1 ? SEQ_ER_KEY1 : SEQ_IDLE;
                SEQ_ER_KEY1:  state_nxt = is_key2 ? SEQ_ER_KEY2 : SEQ_IDLE;
                SEQ_ER_KEY2: begin
                    state_nxt = SEQ_IDLE;
                    if (cmd == CMD_CHIP) begin
                        fire    = 1'b1;
                        fire_op = OP_CHIP_ERASE;
                    end else if (cmd == CMD_SECTOR) begin
                        fire    = 1'b1;
                        fire_op = OP_SECTOR_ERASE;
                    end
                end
                SEQ_IDENT: state_nxt = (cmd == CMD_RESET) ? SEQ_IDLE : SEQ_IDENT;
                default:   state_nxt = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= SEQ_IDLE;
            launch_valid <= 1'b0;
            launch_op    <= OP_NONE;
            launch_addr  <= '0;
            launch_data  <= '0;
        end else begin
            state        <= state_nxt;
            launch_valid <= fire;
            if (fire) begin
                launch_op   <= fire_op;
                launch_addr <= cap_addr;
                launch_data <= cap_data;
            end
        end
    end

    assign mode = mode_of(state);

    // R2
    launch_single_chk: assert property (@(posedge clk) disable iff (rst)
        launch_valid |=> !launch_valid);

    // R2
    launch_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(launch_valid) |-> $past(wr_done));

    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_done && busy) |=> ($stable(state) && !launch_valid));

    // R10
    ident_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_IDENT && wr_done && cap_data[7:0] != CMD_RESET)
        |=> (state == SEQ_IDENT));

endmodule

// File: rtl/ident_read_mux.sv
module ident_read_mux
    import flash_cmd_pkg::*;
#(
    parameter int          ADDR_W    = 18,
    parameter int          SECT_BITS = 3,
    parameter logic [6:0]  MFR_ID7   = 7'h01,
    parameter logic [6:0]  DEV_ID7   = 7'h23,
    parameter logic [7:0]  DEV_ID_HI = 8'h22
) (
    input  logic                      id_active,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      word_mode,
    input  logic [(1<<SECT_BITS)-1:0] sector_prot,
    output logic                      id_valid,
    output logic [15:0]               id_data
);

    localparam int         NUM_SECT = 1 << SECT_BITS;
    localparam logic [7:0] MFR_CODE = odd_parity_byte(MFR_ID7);
    localparam logic [7:0] DEV_CODE = odd_parity_byte(DEV_ID7);

    logic [SECT_BITS-1:0] sect_idx;
    logic [NUM_SECT-1:0]  sect_hit;
    logic                 prot_bit;
    logic                 unused_addr_bits;

    assign sect_idx         = addr[ADDR_W-1 -: SECT_BITS];
    assign unused_addr_bits = ^addr;

    for (genvar g = 0; g < NUM_SECT; g++) begin : g_sect
        assign sect_hit[g] = (sect_idx == SECT_BITS'(g)) && sector_prot[g];
    end

    assign prot_bit = |sect_hit;
    assign id_valid = id_active;

    always_comb begin
        id_data = '0;
        if (id_active) begin
            if (addr[7:0] == 8'h00)
                id_data = {8'h00, MFR_CODE};
            else if (addr[7:0] == 8'h01)
                id_data = word_mode ? {DEV_ID_HI, DEV_CODE} : {8'h00, DEV_CODE};
            else if (!addr[6] && addr[1:0] == 2'b10)
                id_data = {15'd0, prot_bit};
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int         ADDR_W    = 18,
    parameter int         DATA_W    = 16,
    parameter int         SECT_BITS = 3,
    parameter logic [6:0] MFR_ID7   = 7'h01,
    parameter logic [6:0] DEV_ID7   = 7'h23,
    parameter logic [7:0] DEV_ID_HI = 8'h22
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bus_ce_n,
    input  logic                      bus_we_n,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    input  logic                      word_mode,
    input  logic                      busy,
    input  logic [(1<<SECT_BITS)-1:0] sector_prot,
    output logic [1:0]                mode,
    output logic                      launch_valid,
    output logic [1:0]                launch_op,
    output logic [ADDR_W-1:0]         launch_addr,
    output logic [DATA_W-1:0]         launch_data,
    output logic                      id_valid,
    output logic [15:0]               id_data
);

    logic              wr_done;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;
    bus_mode_e         mode_e;
    launch_op_e        op_e;

    bus_write_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_capture (
        .clk      (clk),
        .rst      (rst),
        .ce_n     (bus_ce_n),
        .we_n     (bus_we_n),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .wr_done  (wr_done),
        .cap_addr (cap_addr),
        .cap_data (cap_data)
    );

    cmd_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .wr_done      (wr_done),
        .cap_addr     (cap_addr),
        .cap_data     (cap_data),
        .busy         (busy),
        .mode         (mode_e),
        .launch_valid (launch_valid),
        .launch_op    (op_e),
        .launch_addr  (launch_addr),
        .launch_data  (launch_data)
    );

    ident_read_mux #(
        .ADDR_W    (ADDR_W),
        .SECT_BITS (SECT_BITS),
        .MFR_ID7   (MFR_ID7),
        .DEV_ID7   (DEV_ID7),
        .DEV_ID_HI (DEV_ID_HI)
    ) u_ident (
        .id_active   (mode_e == MODE_IDENT),
        .addr        (bus_addr),
        .word_mode   (word_mode),
        .sector_prot (sector_prot),
        .id_valid    (id_valid),
        .id_data     (id_data)
    );

    assign mode      = mode_e;
    assign launch_op = op_e;

    // R8
    id_parity_chk: assert property (@(posedge clk) disable iff (rst)
        (id_valid && bus_addr[7:1] == 7'd0) |-> (^id_data[7:0]));

    // R12
    id_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'd1) |-> (!id_valid && id_data == 16'h0000));

endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_ce_n = 1'b1;
    logic        bus_we_n = 1'b1;
    logic [17:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        word_mode = 1'b0;
    logic        busy = 1'b0;
    logic [7:0]  sector_prot = 8'b0010_0100;
    logic [1:0]  mode;
    logic        launch_valid;
    logic [1:0]  launch_op;
    logic [17:0] launch_addr;
    logic [15:0] launch_data;
    logic        id_valid;
    logic [15:0] id_data;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    flash_cmd_decoder u_dut (
        .clk (clk), .rst (rst),
        .bus_ce_n (bus_ce_n), .bus_we_n (bus_we_n),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .word_mode (word_mode), .busy (busy), .sector_prot (sector_prot),
        .mode (mode), .launch_valid (launch_valid), .launch_op (launch_op),
        .launch_addr (launch_addr), .launch_data (launch_data),
        .id_valid (id_valid), .id_data (id_data)
    );

    // vector: addr[18] data[16] exp_mode[2] exp_launch[1] exp_op[2] req[4]
    localparam int NV = 39;
    localparam logic [42:0] VEC [NV] = '{
        // R2 program
        {18'h00555, 16'h00AA, 2'd0, 1'b0, 2'd0, 4'd2},
        {18'h002AA, 16'h0055, 2'd0, 1'b0, 2'd0, 4'd2},
        {18'h00555, 16'h00A0, 2'd2, 1'b0, 2'd0, 4'd2},
        {18'h01234, 16'hBEEF, 2'd0, 1'b1, 2'd1, 4'd2},
        // R3 chip erase
        {18'h00555, 16'h00AA, 2'd0, 1'b0, 2'd0, 4'd3},
        {18'h002AA, 16'h0055, 2'd0, 1'b0, 2'd0, 4'd3},
        {18'h00555, 16'h0080, 2'd3, 1'b0, 2'd0, 4'd3},
        {18'h00555, 16'h00AA, 2'd3, 1'b0, 2'd0, 4'd3},
        {18'h002AA, 16'h0055, 2'd3, 1'b0, 2'd0, 4'd3},
        {18'h00555, 16'h0010, 2'd0, 1'b1, 2'd2, 4'd3},
        // R4 sector erase, sector 5
        {18'h00555, 16'h00AA, 2'd0, 1'b0, 2'd0, 4'd4},
        {18'h002AA, 16'h0055, 2'd0, 1'b0, 2'd0, 4'd4},
        {18'h00555, 16'h0080, 2'd3, 1'b0, 2'd0, 4'd4},
        {18'h00555, 16'h00AA, 2'd3, 1'b0, 2'd0, 4'd4},
        {18'h002AA, 16'h0055, 2'd3, 1'b0, 2'd0, 4'd4},
        {18'h28000, 16'h0030, 2'd0, 1'b1, 2'd3, 4'd4},
        // R5 broken unlock address
        {18'h00555, 16'h00AA, 2'd0, 1'b0, 2'd0, 4'd5},
        {18'h002AB, 16'h0055, 2'd0, 1'b0, 2'd0, 4'd5},
        {18'h00555, 16'h00A0, 2'd0, 1'b0, 2'd0, 4'd5},
        {18'h00100, 16'h1234, 2'd0, 1'b0, 2'd0, 4'd5},
        // R5 broken second unlock in erase
        {18'h00555, 16'h00AA, 2'd0, 1'b0, 2'd0, 4'd5},
        {18'h002AA, 16'h0055, 2'd0, 1'b0, 2'd0, 4'd5},
        {18'h00555, 16'h0080, 2'd3, 1'b0, 2'd0, 4'd5},
        {18'h00555, 16'h00AB, 2'd0, 1'b0, 2'd0, 4'd5},
        // R5 unknown erase command
        {18'h00555, 16'h00AA, 2'd0, 1'b0, 2'd0, 4'd5},
        {18'h002AA, 16'h0055, 2'd0, 1'b0, 2'd0, 4'd5},
        {18'h00555, 16'h0080, 2'd3, 1'b0, 2'd0, 4'd5},
        {18'h00555, 16'h00AA, 2'd3, 1'b0, 2'd0, 4'd5},
        {18'h002AA, 16'h0055, 2'd3, 1'b0, 2'd0, 4'd5},
        {18'h00555, 16'h0020, 2'd0, 1'b0, 2'd0, 4'd5},
        // R7 enter identification, R10 writes inside it
        {18'h00555, 16'h00AA, 2'd0, 1'b0, 2'd0, 4'd7},
        {18'h002AA, 16'h0055, 2'd0, 1'b0, 2'd0, 4'd7},
        {18'h00555, 16'h0090, 2'd1, 1'b0, 2'd0, 4'd7},
        {18'h00555, 16'h00AA, 2'd1, 1'b0, 2'd0, 4'd10},
        {18'h002AA, 16'h0055, 2'd1, 1'b0, 2'd0, 4'd10},
        {18'h00555, 16'h00A0, 2'd1, 1'b0, 2'd0, 4'd10},
        {18'h00100, 16'h1234, 2'd1, 1'b0, 2'd0, 4'd10},
        {18'h00000, 16'h00F0, 2'd0, 1'b0, 2'd0, 4'd10},
        // R5 reset byte in read mode
        {18'h00000, 16'h00F0, 2'd0, 1'b0, 2'd0, 4'd5}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one write; returns at the negedge after the cycle that completes it
    task automatic do_write(input logic [17:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_ce_n = 1'b0; bus_we_n = 1'b0;
        @(negedge clk);
        bus_ce_n = 1'b1; bus_we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic enter_ident();
        do_write(18'h00555, 16'h00AA);
        do_write(18'h002AA, 16'h0055);
        do_write(18'h00555, 16'h0090);
    endtask

    task automatic read_id(input logic [17:0] a, input logic [15:0] exp, input string req);
        @(negedge clk);
        bus_addr = a;
        #0.5;
        check(req, {16'h0, id_data}, {16'h0, exp});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 mode", {30'h0, mode}, 32'd0);
        check("R1 launch_valid", {31'h0, launch_valid}, 32'd0);
        check("R1 id_valid", {31'h0, id_valid}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [17:0] va; logic [15:0] vd; logic [1:0] vm; logic vl; logic [1:0] vo;
            string tag;
            {va, vd, vm, vl, vo} = VEC[i][42:4];
            tag = $sformatf("R%0d vec%0d", VEC[i][3:0], i);
            do_write(va, vd);
            check({tag, " mode"}, {30'h0, mode}, {30'h0, vm});
            check({tag, " launch"}, {31'h0, launch_valid}, {31'h0, vl});
            if (vl) begin
                check({tag, " op"}, {30'h0, launch_op}, {30'h0, vo});
                check({tag, " addr"}, {14'h0, launch_addr}, {14'h0, va});
                check({tag, " data"}, {16'h0, launch_data}, {16'h0, vd});
            end
        end

        // R6 staggered strobes, moving address and data
        do_write(18'h00555, 16'h00AA);
        do_write(18'h002AA, 16'h0055);
        do_write(18'h00555, 16'h00A0);
        @(negedge clk); bus_ce_n = 1'b0; bus_we_n = 1'b1; bus_addr = 18'h00111; bus_wdata = 16'h1111;
        @(negedge clk); bus_we_n = 1'b0; bus_addr = 18'h00222; bus_wdata = 16'h2222;
        @(negedge clk); bus_addr = 18'h00333; bus_wdata = 16'h4444;
        @(negedge clk); bus_we_n = 1'b1; bus_addr = 18'h00444; bus_wdata = 16'h5555;
        @(negedge clk); bus_ce_n = 1'b1;
        check("R6 launch", {31'h0, launch_valid}, 32'd1);
        check("R6 addr at later fall", {14'h0, launch_addr}, 32'h00222);
        check("R6 data before rise", {16'h0, launch_data}, 32'h4444);
        @(negedge clk);
        check("R2 single cycle pulse", {31'h0, launch_valid}, 32'd0);

        // R11 busy during program data write
        do_write(18'h00555, 16'h00AA);
        do_write(18'h002AA, 16'h0055);
        do_write(18'h00555, 16'h00A0);
        busy = 1'b1;
        do_write(18'h00200, 16'h0F0F);
        check("R11 no launch when busy", {31'h0, launch_valid}, 32'd0);
        check("R11 mode kept when busy", {30'h0, mode}, 32'd2);
        busy = 1'b0;
        do_write(18'h00300, 16'h3C3C);
        check("R11 launch after busy", {31'h0, launch_valid}, 32'd1);
        check("R11 launch addr", {14'h0, launch_addr}, 32'h00300);
        // R11 busy during unlock
        busy = 1'b1;
        do_write(18'h00555, 16'h00AA);
        busy = 1'b0;
        do_write(18'h002AA, 16'h0055);
        do_write(18'h00555, 16'h0090);
        check("R11 ignored unlock", {30'h0, mode}, 32'd0);

        // R7 / R8 / R9 identification reads
        enter_ident();
        check("R7 mode", {30'h0, mode}, 32'd1);
        check("R7 id_valid", {31'h0, id_valid}, 32'd1);
        word_mode = 1'b0;
        read_id(18'h00000, 16'h0001, "R8 manufacturer");
        read_id(18'h00001, 16'h0023, "R8 device byte mode");
        word_mode = 1'b1;
        read_id(18'h00001, 16'h2223, "R8 device word mode");
        read_id(18'h3FF00, 16'h0001, "R8 manufacturer high bits ignored");
        read_id(18'h10002, 16'h0001, "R9 sector 2 protected");
        read_id(18'h28002, 16'h0001, "R9 sector 5 protected");
        read_id(18'h18002, 16'h0000, "R9 sector 3 open");
        read_id(18'h10042, 16'h0000, "R9 A6 set gives no flag");
        sector_prot = 8'b0000_1000;
        read_id(18'h18002, 16'h0001, "R9 sector 3 now protected");
        // R11 exit write ignored while busy
        busy = 1'b1;
        do_write(18'h00000, 16'h00F0);
        busy = 1'b0;
        check("R11 ident kept when busy", {30'h0, mode}, 32'd1);
        do_write(18'h00000, 16'h00F0);
        check("R10 exit on F0", {30'h0, mode}, 32'd0);

        // R12 quiet outside identification
        read_id(18'h00000, 16'h0000, "R12 id_data in read mode");
        check("R12 id_valid", {31'h0, id_valid}, 32'd0);
        do_write(18'h00555, 16'h00AA);
        do_write(18'h002AA, 16'h0055);
        do_write(18'h00555, 16'h00A0);
        read_id(18'h00001, 16'h0000, "R12 id_data in program mode");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule